// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block models one wide bidirectional transceiver with two independent data paths: one carries the A-side data toward the B side, the other carries B-side data toward the A side. Each path owns a storage register, a pass (latch) enable, a capture strobe and a driver enable. With the pass enable high the path reloads its storage from its input on every system-clock cycle, so its output follows the input one cycle later. With the pass enable low the storage keeps its value until the strobe rises. The strobe is an ordinary synchronous input sampled by the single system clock `clk`. Bidirectional pins are split into an input, an output value and a driver-enable per side. The output value always carries the stored data; the driver enable decides whether it reaches the pin.

Each path runs two small state machines. The strobe tracker has states `STB_LOW` and `STB_HIGH`. The transition `STB_LOW -> STB_HIGH` is the rising edge, which raises a one-cycle `rise` pulse. `STB_HIGH -> STB_LOW` follows a low sample. The other two transitions are self-loops. On reset the tracker adopts the present strobe level, so a strobe that is already high at reset release is not seen as an edge. The store selects one mode each cycle, in priority order: `MODE_PASS` (pass enable high, load the input), `MODE_CAPTURE` (pass enable low and `rise`, load the input), and `MODE_HOLD` (otherwise, keep the stored value). The A-to-B driver enable is active high. The B-to-A driver enable is active low. While `rst` is high both drivers are off.

Top module: `ubt_transceiver`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, both stored values become zero. While `rst` is high, `a_oe` and `b_oe` are both 0.
- R2: While `ab_pass_en` is 1, `b_out` after each `clk` edge equals `a_in` as sampled at that edge.
- R3: While `ab_pass_en` is 0 and `ab_strobe` keeps the same level at consecutive edges, `b_out` keeps its value whatever `a_in` does.
- R4: While `ab_pass_en` is 0, an edge at which `ab_strobe` is sampled 1 after being sampled 0 at the previous edge loads `a_in` into storage, so `b_out` shows it.
- R5: If `ab_pass_en` falls while `ab_strobe` is high, `b_out` keeps the value last passed. No load happens until `ab_strobe` has gone low and then high again.
- R6: Outside reset, `b_oe` equals `ab_drive_en`, so the A-to-B driver enable is active high.
- R7: Outside reset, `a_oe` equals the inverse of `ba_drive_en_n`, so the B-to-A driver enable is active low.
- R8: Pass and capture continue while a side's driver is off. The stored value appears on `b_out` or `a_out` whatever the driver enable is.
- R9: The B-to-A path follows R2 to R5 with `ba_pass_en`, `ba_strobe`, `b_in` and `a_out`, independently of the A-to-B path.
- R10: A strobe that is high at reset release causes no load. While the pass enable is high, a strobe rise loads the same input that passing would load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | DW | Data sampled from the A-side pins |
| a_out | output | DW | Stored B-to-A value offered to the A-side pins |
| a_oe | output | 1 | A-side driver enable (0 = high impedance) |
| b_in | input | DW | Data sampled from the B-side pins |
| b_out | output | DW | Stored A-to-B value offered to the B-side pins |
| b_oe | output | 1 | B-side driver enable (0 = high impedance) |
| ab_drive_en | input | 1 | A-to-B driver enable, active high |
| ab_pass_en | input | 1 | A-to-B pass (transparent) enable |
| ab_strobe | input | 1 | A-to-B capture strobe, loads on its rising edge |
| ba_drive_en_n | input | 1 | B-to-A driver enable, active low |
| ba_pass_en | input | 1 | B-to-A pass (transparent) enable |
| ba_strobe | input | 1 | B-to-A capture strobe, loads on its rising edge |

## Verification
Some rules can be checked on every cycle at the point where each path is built, and the assertions cover these. They check that pass mode loads the sampled input, that capture happens only on a detected rise, and that hold mode keeps storage stable. They also check that a rise pulse never lasts two cycles, and that the driver enables stay off during reset. Other behaviour needs an ordered sequence of stimulus and is shown only by the bench scenarios. This covers a pass enable falling while the strobe is high, a strobe held high across reset release, the two enable polarities seen at the ports, data captured while a driver is off, and the two directions running independently.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
    typedef enum logic {
        STB_LOW  = 1'b0,
        STB_HIGH = 1'b1
    } stb_state_t;

    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,
        MODE_PASS    = 2'd1,
        MODE_CAPTURE = 2'd2
    } store_mode_t;
endpackage

// File: rtl/ubt_strobe_track.sv
module ubt_strobe_track
    import ubt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise
);
    stb_state_t state_q;
    stb_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= strobe ? STB_HIGH : STB_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        unique case (state_q)
            STB_LOW: begin
                if (strobe) begin
                    state_d = STB_HIGH;
                    rise    = 1'b1;
                end
            end
            STB_HIGH: begin
                if (!strobe) begin
                    state_d = STB_LOW;
                end
            end
            default: state_d = STB_LOW;
        endcase
    end

    // R4
    rise_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
        rise |-> strobe);

    // R5
    rise_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/ubt_store.sv
module ubt_store
    import ubt_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  logic          pass_en,
    input  logic          rise,
    output logic [DW-1:0] q
);
    store_mode_t   mode;
    logic [DW-1:0] q_r;

    always_comb begin
        if (pass_en) begin
            mode = MODE_PASS;
        end else if (rise) begin
            mode = MODE_CAPTURE;
        end else begin
            mode = MODE_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else begin
            unique case (mode)
                MODE_PASS:    q_r <= din;
                MODE_CAPTURE: q_r <= din;
                MODE_HOLD:    q_r <= q_r;
                default:      q_r <= q_r;
            endcase
        end
    end

    assign q = q_r;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (q == '0));

    // R2
    pass_load_chk: assert property (@(posedge clk) disable iff (rst)
        pass_en |=> (q == $past(din)));

    // R4
    capture_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!pass_en && rise) |=> (q == $past(din)));

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!pass_en && !rise) |=> $stable(q));
endmodule

// File: rtl/ubt_path.sv
module ubt_path #(
    parameter int DW      = 18,
    parameter bit OE_LOW  = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  logic          drive_ctl,
    input  logic          pass_en,
    input  logic          strobe,
    output logic [DW-1:0] dout,
    output logic          oe
);
    logic rise;
    logic drive_on;

    ubt_strobe_track u_track (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .rise   (rise)
    );

    ubt_store #(.DW(DW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .pass_en (pass_en),
        .rise    (rise),
        .q       (dout)
    );

    generate
        if (OE_LOW) begin : g_oe_low
            assign drive_on = !drive_ctl;
        end else begin : g_oe_high
            assign drive_on = drive_ctl;
        end
    endgenerate

    assign oe = drive_on && !rst;

    // R1
    reset_no_drive_chk: assert property (@(posedge clk)
        rst |-> !oe);
endmodule

// File: rtl/ubt_transceiver.sv
module ubt_transceiver #(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] a_in,
    output logic [DW-1:0] a_out,
    output logic          a_oe,
    input  logic [DW-1:0] b_in,
    output logic [DW-1:0] b_out,
    output logic          b_oe,
    input  logic          ab_drive_en,
    input  logic          ab_pass_en,
    input  logic          ab_strobe,
    input  logic          ba_drive_en_n,
    input  logic          ba_pass_en,
    input  logic          ba_strobe
);
    ubt_path #(.DW(DW), .OE_LOW(1'b0)) u_ab (
        .clk       (clk),
        .rst       (rst),
        .din       (a_in),
        .drive_ctl (ab_drive_en),
        .pass_en   (ab_pass_en),
        .strobe    (ab_strobe),
        .dout      (b_out),
        .oe        (b_oe)
    );

    ubt_path #(.DW(DW), .OE_LOW(1'b1)) u_ba (
        .clk       (clk),
        .rst       (rst),
        .din       (b_in),
        .drive_ctl (ba_drive_en_n),
        .pass_en   (ba_pass_en),
        .strobe    (ba_strobe),
        .dout      (a_out),
        .oe        (a_oe)
    );

    // R6
    ab_polarity_chk: assert property (@(posedge clk) disable iff (rst)
        ab_drive_en |-> b_oe);

    // R7
    ba_polarity_chk: assert property (@(posedge clk) disable iff (rst)
        ba_drive_en_n |-> !a_oe);
endmodule

// File: tb/ubt_transceiver_bench.sv
`timescale 1ns/1ps
module ubt_transceiver_bench;
    localparam int DW = 18;

    typedef struct {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic          aoe;
        logic          boe;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] a_in, b_in, a_out, b_out;
    logic          a_oe, b_oe;
    logic          ab_drive_en, ab_pass_en, ab_strobe;
    logic          ba_drive_en_n, ba_pass_en, ba_strobe;

    // staged stimulus
    logic          s_rst = 1'b1;
    logic [DW-1:0] s_a = '0, s_b = '0;
    logic          s_abd = 1'b0, s_abp = 1'b0, s_abs = 1'b0;
    logic          s_bad = 1'b1, s_bap = 1'b0, s_bas = 1'b0;

    // reference model
    logic [DW-1:0] m_b = '0, m_a = '0;
    logic          m_pab = 1'b0, m_pba = 1'b0;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #2.5 clk = ~clk;

    ubt_transceiver #(.DW(DW)) u_ubt_transceiver (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_drive_en(ab_drive_en), .ab_pass_en(ab_pass_en), .ab_strobe(ab_strobe),
        .ba_drive_en_n(ba_drive_en_n), .ba_pass_en(ba_pass_en), .ba_strobe(ba_strobe)
    );

    initial begin
        rst = 1'b1; a_in = '0; b_in = '0;
        ab_drive_en = 1'b0; ab_pass_en = 1'b0; ab_strobe = 1'b0;
        ba_drive_en_n = 1'b1; ba_pass_en = 1'b0; ba_strobe = 1'b0;
    end

    task automatic tick(input string tag);
        exp_t e;
        @(negedge clk);
        rst = s_rst; a_in = s_a; b_in = s_b;
        ab_drive_en = s_abd; ab_pass_en = s_abp; ab_strobe = s_abs;
        ba_drive_en_n = s_bad; ba_pass_en = s_bap; ba_strobe = s_bas;
        if (s_rst) begin
            m_b = '0; m_a = '0;
        end else begin
            if (s_abp || (s_abs && !m_pab)) m_b = s_a;
            if (s_bap || (s_bas && !m_pba)) m_a = s_b;
        end
        m_pab = s_abs; m_pba = s_bas;
        e.a = m_a; e.b = m_b;
        e.boe = !s_rst && s_abd;
        e.aoe = !s_rst && !s_bad;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic cmp(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, "b_out", b_out, e.b);
            cmp(e.tag, "a_out", a_out, e.a);
            cmp(e.tag, "b_oe", {{(DW-1){1'b0}}, b_oe}, {{(DW-1){1'b0}}, e.boe});
            cmp(e.tag, "a_oe", {{(DW-1){1'b0}}, a_oe}, {{(DW-1){1'b0}}, e.aoe});
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset with both enables requesting drive and strobe high
        s_abd = 1'b1; s_bad = 1'b0; s_abs = 1'b1; s_a = 18'h1234;
        repeat (3) tick("R1");
        // R10 strobe high through reset release: no load
        s_rst = 1'b0;
        tick("R10");
        tick("R10");
        // R2 transparent A to B
        s_abp = 1'b1;
        s_a = 18'h0AAAA; tick("R2");
        s_a = 18'h15555; tick("R2");
        s_a = 18'h3FFFF; tick("R2");
        s_a = 18'h00001; tick("R2");
        // R5 pass falls while strobe high: keep value
        s_abp = 1'b0; s_a = 18'h2BEEF; tick("R5");
        s_a = 18'h13579; tick("R5");
        s_abs = 1'b0; s_a = 18'h0F0F0; tick("R5");
        // R4 capture on rising strobe
        s_abs = 1'b1; s_a = 18'h24680; tick("R4");
        // R3 hold with strobe steady high then low
        s_a = 18'h11111; tick("R3");
        s_a = 18'h22222; tick("R3");
        s_abs = 1'b0; s_a = 18'h33333; tick("R3");
        s_a = 18'h0ABCD; tick("R3");
        // R6 active-high A-to-B driver enable, R8 capture while off
        s_abd = 1'b0; tick("R6");
        s_abs = 1'b1; s_a = 18'h3C3C3; tick("R8");
        s_abs = 1'b0; s_abp = 1'b1; s_a = 18'h05A5A; tick("R8");
        s_abd = 1'b1; tick("R6");
        // R10 pass high with strobe rise loads same input
        s_abs = 1'b1; s_a = 18'h1E1E1; tick("R10");
        s_abp = 1'b0; s_abs = 1'b0; tick("R10");
        // R7 active-low B-to-A driver enable
        s_bad = 1'b1; tick("R7");
        s_bad = 1'b0; tick("R7");
        // R9 B-to-A path, independent of A-to-B
        s_bap = 1'b1; s_b = 18'h2DEAD; tick("R9");
        s_b = 18'h0C0DE; tick("R9");
        s_bas = 1'b1; s_bap = 1'b0; s_b = 18'h3AAAA; tick("R9");
        s_bas = 1'b0; s_b = 18'h01234; tick("R9");
        s_bas = 1'b1; s_b = 18'h04321; s_a = 18'h3FFF0; tick("R9");
        // R8 B-to-A capture while driver off
        s_bad = 1'b1; s_bas = 1'b0; tick("R8");
        s_bas = 1'b1; s_b = 18'h17777; tick("R8");
        tick("R8");
        // R1 reset again mid-run
        s_rst = 1'b1; tick("R1");
        s_rst = 1'b0; s_bad = 1'b0; tick("R1");
        repeat (2) @(posedge clk);
        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule